// File: doc/BRIEF.md
# Command-Byte I2C Register Target

This block is an I2C target for a two-channel attenuator controller. It samples SCL and SDA with the system clock and drives SDA through an open-drain enable. Its seven-bit address is a fixed upper nibble followed by three strap pins. An active-low chip enable decides whether the bus is seen at all. There is no address pointer. In a write, every data byte is a command, and its two top bits name the target: wiper 0, wiper 1 or the configuration register.

The block keeps the three values in shadow registers and presents them as outputs. It gives a one-cycle strobe, with the written field, each time a value is updated. A separate strobe marks the stop condition that closes a write transaction. A storage sequencer can use that strobe to start a commit. While the sequencer raises its busy input, the block does not acknowledge its address, so a master can poll for completion.

Reads always start at wiper 0. They then rotate through wiper 1 and configuration, and wrap back to wiper 0 for as long as the master acknowledges.

Top module: `dvol_i2c_target`

## Requirements
- R1: The block acknowledges a first byte whose upper seven bits equal binary 0101 followed by addr_pins[2:0], but only while busy_i is low. The least significant bit selects read (1) or write (0).
- R2: While ce_n is high, SCL and SDA are ignored: there is no acknowledge, no register change, and sda_oe is low.
- R3: A write byte with bits 7:6 = 00 loads bits 5:0 into wiper 0. With bits 7:6 = 01 it loads bits 5:0 into wiper 1. The update and its strobe (wr_w0_o or wr_w1_o, with wr_data_o = bits 5:0) appear in the same cycle.
- R4: A write byte with bits 7:6 = 10 loads bits 2:0 into the configuration register and pulses wr_cfg_o. Bits 5:3 are ignored.
- R5: A write byte with bits 7:6 = 11 is acknowledged, but changes no register and produces no strobe.
- R6: One write transaction may carry any number of command bytes in any order, and each one takes effect.
- R7: Read bytes come in the order wiper 0 = {00,w0}, wiper 1 = {01,w1}, configuration = {10,000,cfg}. The order wraps to wiper 0 while the master acknowledges.
- R8: Every addressed read, including one after a repeated start, begins with wiper 0.
- R9: After an address mismatch the block neither acknowledges nor acts on any byte until the next start condition.
- R10: Data is taken on rising SCL. The block changes sda_oe only while SCL is low, sends the most significant bit first, and uses the ninth bit as the acknowledge.
- R11: Strobes last one cycle, and at most one register strobe is active at a time. stop_o pulses on a stop condition when at least one wiper or configuration byte was applied since the previous stop.
- R12: After reset, both wipers read 6'h3F (mute), configuration reads 3'b111, and sda_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Active-low bus enable |
| addr_pins | input | 3 | Low three address bits |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy_i | input | 1 | Storage sequencer busy; suppresses address acknowledge |
| wr_w0_o | output | 1 | Wiper 0 update strobe |
| wr_w1_o | output | 1 | Wiper 1 update strobe |
| wr_cfg_o | output | 1 | Configuration update strobe |
| wr_data_o | output | 6 | Low six bits of the applied command byte |
| stop_o | output | 1 | Stop closing a write transaction that applied a value |
| wiper0_o | output | 6 | Wiper 0 setting |
| wiper1_o | output | 6 | Wiper 1 setting |
| cfg_o | output | 3 | Configuration bits |

## Verification
The assertions rely on a few properties of the bus. Every SCL low phase must last longer than the three-cycle synchroniser and edge-detect delay. The master never issues a start or stop while the block holds SDA low. ce_n and addr_pins change only while the bus is idle. The stimulus meets these conditions by building each bit from four eight-cycle quarters, changing SDA only in the quarter after SCL falls, and changing the enable, strap pins and busy input only between complete transactions.

// File: rtl/dvol_pkg.sv
// Shared constants and types for the command-byte I2C target.
// Assumes 8-bit bus bytes and three addressable registers.
package dvol_pkg;
    localparam int BYTE_W  = 8;
    localparam int WIPER_W = 6;
    localparam int CFG_W   = 3;
    localparam int CNT_W   = $clog2(BYTE_W);
    localparam int NREGS   = 3;
    localparam int PTR_W   = $clog2(NREGS);

    typedef enum logic [1:0] {
        SEL_W0  = 2'b00,
        SEL_W1  = 2'b01,
        SEL_CFG = 2'b10,
        SEL_RSV = 2'b11
    } sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_RLOAD
    } state_e;
endpackage

// File: rtl/dvol_bus_sync.sv
// Brings SCL and SDA into the clock domain and flags bus events.
// Assumes both lines idle high; needs STAGES >= 2.
module dvol_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_s;
    logic              scl_d;
    logic              sda_d;

    // Synchroniser chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    // Edge and condition decode on the synchronised levels.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/dvol_regfile.sv
// Shadow registers: decodes command bytes, emits strobes, builds readback bytes.
// Assumes wr_en is a single-cycle pulse carrying a complete command byte.
module dvol_regfile
    import dvol_pkg::*;
#(
    parameter logic [WIPER_W-1:0] WIPER_RST = '1,
    parameter logic [CFG_W-1:0]   CFG_RST   = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [BYTE_W-1:0]  wr_byte,
    input  logic [PTR_W-1:0]   rd_ptr,
    output logic [BYTE_W-1:0]  rd_byte,
    output logic               applied,
    output logic [WIPER_W-1:0] wiper0_o,
    output logic [WIPER_W-1:0] wiper1_o,
    output logic [CFG_W-1:0]   cfg_o,
    output logic               wr_w0_o,
    output logic               wr_w1_o,
    output logic               wr_cfg_o,
    output logic [WIPER_W-1:0] wr_data_o
);
    localparam int PAD_W = BYTE_W - 2 - CFG_W;

    sel_e sel;

    // Target selection from the two top bits of the command.
    always_comb begin
        sel     = sel_e'(wr_byte[BYTE_W-1 -: 2]);
        applied = wr_en && (sel != SEL_RSV);
    end

    // Register update with a matching one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wiper0_o  <= WIPER_RST;
            wiper1_o  <= WIPER_RST;
            cfg_o     <= CFG_RST;
            wr_w0_o   <= 1'b0;
            wr_w1_o   <= 1'b0;
            wr_cfg_o  <= 1'b0;
            wr_data_o <= '0;
        end else begin
            wr_w0_o  <= 1'b0;
            wr_w1_o  <= 1'b0;
            wr_cfg_o <= 1'b0;
            if (wr_en) begin
                wr_data_o <= wr_byte[WIPER_W-1:0];
                unique case (sel)
                    SEL_W0:  begin wiper0_o <= wr_byte[WIPER_W-1:0]; wr_w0_o  <= 1'b1; end
                    SEL_W1:  begin wiper1_o <= wr_byte[WIPER_W-1:0]; wr_w1_o  <= 1'b1; end
                    SEL_CFG: begin cfg_o    <= wr_byte[CFG_W-1:0];   wr_cfg_o <= 1'b1; end
                    SEL_RSV: ;
                endcase
            end
        end
    end

    // Readback byte for the current rotation slot, tagged with its prefix.
    always_comb begin
        unique case (rd_ptr)
            2'd0:    rd_byte = {SEL_W0, wiper0_o};
            2'd1:    rd_byte = {SEL_W1, wiper1_o};
            default: rd_byte = {SEL_CFG, {PAD_W{1'b0}}, cfg_o};
        endcase
    end
endmodule

// File: rtl/dvol_target_fsm.sv
// Byte-level protocol engine: address match, acknowledge, write capture and
// rotating readback. Assumes synchronised, edge-decoded bus events as input.
module dvol_target_fsm
    import dvol_pkg::*;
#(
    parameter logic [3:0] ADDR_HI = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic [2:0]        addr_pins,
    input  logic              busy_i,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_byte,
    input  logic              applied,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_byte,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic              stop_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NREGS - 1);

    state_e            state;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              rw;
    logic              dirty;

    // Protocol sequencing; the enable, stop and start take priority over the byte states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bit_cnt <= '0;
            rw      <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_byte <= '0;
            rd_ptr  <= '0;
            dirty   <= 1'b0;
            stop_o  <= 1'b0;
        end else begin
            wr_en  <= 1'b0;
            stop_o <= 1'b0;
            if (applied) dirty <= 1'b1;
            if (ce_n) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                dirty  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                stop_o <= dirty;
                dirty  <= 1'b0;
            end else if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                rd_ptr  <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ADDR: if (scl_rise) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST_BIT) begin
                            if (shreg[BYTE_W-2:0] == {ADDR_HI, addr_pins} && !busy_i) begin
                                rw    <= sda_s;
                                state <= ST_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: if (scl_fall) begin
                        bit_cnt <= '0;
                        if (!sda_oe) begin
                            sda_oe <= 1'b1;
                        end else if (rw) begin
                            shreg  <= rd_byte;
                            sda_oe <= ~rd_byte[BYTE_W-1];
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_WDATA: if (scl_rise) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST_BIT) begin
                            wr_en   <= 1'b1;
                            wr_byte <= {shreg[BYTE_W-2:0], sda_s};
                            state   <= ST_ACK;
                        end
                    end
                    ST_RDATA: if (scl_fall) begin
                        if (bit_cnt == LAST_BIT) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else begin
                            shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe  <= ~shreg[BYTE_W-2];
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_RACK: if (scl_rise) begin
                        if (!sda_s) begin
                            rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
                            state  <= ST_RLOAD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_RLOAD: if (scl_fall) begin
                        shreg   <= rd_byte;
                        sda_oe  <= ~rd_byte[BYTE_W-1];
                        bit_cnt <= '0;
                        state   <= ST_RDATA;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/dvol_i2c_target.sv
// Top level of the command-byte I2C target: synchroniser, protocol engine
// and shadow registers. Assumes the system clock oversamples SCL well.
module dvol_i2c_target
    import dvol_pkg::*;
#(
    parameter int                 SYNC_STAGES = 2,
    parameter logic [3:0]         ADDR_HI     = 4'b0101,
    parameter logic [WIPER_W-1:0] WIPER_RST   = 6'h3F,
    parameter logic [CFG_W-1:0]   CFG_RST     = 3'b111
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_n,
    input  logic [2:0]         addr_pins,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic               busy_i,
    output logic               wr_w0_o,
    output logic               wr_w1_o,
    output logic               wr_cfg_o,
    output logic [WIPER_W-1:0] wr_data_o,
    output logic               stop_o,
    output logic [WIPER_W-1:0] wiper0_o,
    output logic [WIPER_W-1:0] wiper1_o,
    output logic [CFG_W-1:0]   cfg_o
);
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_byte;
    logic [PTR_W-1:0]  rd_ptr;
    logic [BYTE_W-1:0] rd_byte;
    logic              applied;

    dvol_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    dvol_target_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .addr_pins (addr_pins),
        .busy_i    (busy_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_byte   (rd_byte),
        .applied   (applied),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_byte   (wr_byte),
        .rd_ptr    (rd_ptr),
        .stop_o    (stop_o)
    );

    dvol_regfile #(.WIPER_RST(WIPER_RST), .CFG_RST(CFG_RST)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_byte   (wr_byte),
        .rd_ptr    (rd_ptr),
        .rd_byte   (rd_byte),
        .applied   (applied),
        .wiper0_o  (wiper0_o),
        .wiper1_o  (wiper1_o),
        .cfg_o     (cfg_o),
        .wr_w0_o   (wr_w0_o),
        .wr_w1_o   (wr_w1_o),
        .wr_cfg_o  (wr_cfg_o),
        .wr_data_o (wr_data_o)
    );
endmodule

// File: rtl/dvol_target_chk.sv
// Port-level properties of the I2C target, attached by bind.
// Assumes SCL low phases outlast the synchroniser delay.
module dvol_target_chk #(
    parameter logic [5:0] WIPER_RST = 6'h3F,
    parameter logic [2:0] CFG_RST   = 3'b111
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       wr_w0_o,
    input logic       wr_w1_o,
    input logic       wr_cfg_o,
    input logic [5:0] wr_data_o,
    input logic       stop_o,
    input logic [5:0] wiper0_o,
    input logic [5:0] wiper1_o,
    input logic [2:0] cfg_o
);
    // R11
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_w0_o, wr_w1_o, wr_cfg_o}));
    // R11
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_w0_o || wr_w1_o || wr_cfg_o) |=> !(wr_w0_o || wr_w1_o || wr_cfg_o));
    // R11
    stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o);
    // R3
    w0_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper0_o) |-> wr_w0_o);
    // R3
    w0_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_w0_o |-> wiper0_o == wr_data_o);
    // R3
    w1_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper1_o) |-> wr_w1_o);
    // R3
    w1_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_w1_o |-> wiper1_o == wr_data_o);
    // R4
    cfg_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> wr_cfg_o);
    // R4
    cfg_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg_o |-> cfg_o == wr_data_o[2:0]);
    // R2
    ce_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n) |-> !sda_oe);
    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);
    // R12
    reset_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (wiper0_o == WIPER_RST && wiper1_o == WIPER_RST
                           && cfg_o == CFG_RST && !sda_oe));
endmodule

bind dvol_i2c_target dvol_target_chk #(.WIPER_RST(WIPER_RST), .CFG_RST(CFG_RST)) u_chk (.*);

// File: tb/test_dvol_i2c_target.sv
module test_dvol_i2c_target;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam logic [6:0] DEV = 7'h2A;   // 0101 + pins 010
    localparam int NV = 7;
    // {cmd, exp w0, exp w1, exp cfg, applied}
    localparam logic [23:0] VECS [NV] = '{
        {8'h05, 6'h05, 6'h3F, 3'h7, 1'b1},
        {8'h4A, 6'h05, 6'h0A, 3'h7, 1'b1},
        {8'h82, 6'h05, 6'h0A, 3'h2, 1'b1},
        {8'hC1, 6'h05, 6'h0A, 3'h2, 1'b0},
        {8'h21, 6'h21, 6'h0A, 3'h2, 1'b1},
        {8'hB9, 6'h21, 6'h0A, 3'h1, 1'b1},
        {8'h7F, 6'h21, 6'h3F, 3'h1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b0;
    logic [2:0] addr_pins = 3'b010;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       busy_i = 1'b0;
    logic       sda_oe, wr_w0_o, wr_w1_o, wr_cfg_o, stop_o;
    logic [5:0] wr_data_o, wiper0_o, wiper1_o;
    logic [2:0] cfg_o;
    logic       sda_bus;
    int n_checks = 0;
    int n_err = 0;
    int strobe_cnt = 0;
    int stop_cnt = 0;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    dvol_i2c_target i_dvol_i2c_target (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .addr_pins(addr_pins),
        .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe), .busy_i(busy_i),
        .wr_w0_o(wr_w0_o), .wr_w1_o(wr_w1_o), .wr_cfg_o(wr_cfg_o),
        .wr_data_o(wr_data_o), .stop_o(stop_o), .wiper0_o(wiper0_o),
        .wiper1_o(wiper1_o), .cfg_o(cfg_o)
    );

    always @(negedge clk) begin
        if (wr_w0_o || wr_w1_o || wr_cfg_o) strobe_cnt++;
        if (stop_o) stop_cnt++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic quarter();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; quarter();
        scl_m = 1'b1; quarter();
        sda_m = 1'b0; quarter();
        scl_m = 1'b0; quarter();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; quarter();
        scl_m = 1'b1; quarter();
        sda_m = 1'b1; quarter();
    endtask

    task automatic write_bit(input logic b);
        sda_m = b;    quarter();
        scl_m = 1'b1; quarter(); quarter();
        scl_m = 1'b0; quarter();
    endtask

    task automatic read_bit(output logic b);
        sda_m = 1'b1; quarter();
        scl_m = 1'b1; quarter();
        b = sda_bus;  quarter();
        scl_m = 1'b0; quarter();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) write_bit(d[i]);
        read_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) read_bit(d[i]);
        write_bit(~mack);
    endtask

    task automatic write1(input logic [6:0] a, input logic [7:0] cmd,
                          output logic ack_a, output logic ack_d);
        i2c_start();
        send_byte({a, 1'b0}, ack_a);
        send_byte(cmd, ack_d);
        i2c_stop();
        quarter();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic a1, a2, a3;
        logic [7:0] d;
        int s0, p0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        quarter();
        // R12 reset state
        chk("R12 wiper0 reset", wiper0_o, 6'h3F);
        chk("R12 wiper1 reset", wiper1_o, 6'h3F);
        chk("R12 cfg reset", cfg_o, 3'h7);
        chk("R12 sda_oe reset", sda_oe, 0);

        // Vector table: one command byte per write transaction (R3 R4 R5 R11)
        for (int v = 0; v < NV; v++) begin
            s0 = strobe_cnt; p0 = stop_cnt;
            write1(DEV, VECS[v][23:16], a1, a2);
            chk("R1 address ack", a1, 1);
            chk("R5 command ack", a2, 1);
            chk("R3 wiper0", wiper0_o, VECS[v][15:10]);
            chk("R3 wiper1", wiper1_o, VECS[v][9:4]);
            chk("R4 cfg", cfg_o, VECS[v][3:1]);
            chk("R5 strobe count", strobe_cnt - s0, VECS[v][0]);
            chk("R11 stop strobe", stop_cnt - p0, VECS[v][0]);
        end

        // R6 several commands in one transaction
        s0 = strobe_cnt; p0 = stop_cnt;
        i2c_start();
        send_byte({DEV, 1'b0}, a1);
        send_byte(8'h4C, a2);
        send_byte(8'h11, a3);
        send_byte(8'h83, a3);
        i2c_stop(); quarter();
        chk("R6 wiper0", wiper0_o, 6'h11);
        chk("R6 wiper1", wiper1_o, 6'h0C);
        chk("R6 cfg", cfg_o, 3'h3);
        chk("R6 strobes", strobe_cnt - s0, 3);
        chk("R11 single stop", stop_cnt - p0, 1);

        // R7 R10 rotating read with wrap
        i2c_start();
        send_byte({DEV, 1'b1}, a1);
        chk("R1 read ack", a1, 1);
        recv_byte(1'b1, d); chk("R7 R10 byte0 wiper0", d, 8'h11);
        recv_byte(1'b1, d); chk("R7 byte1 wiper1", d, 8'h4C);
        recv_byte(1'b1, d); chk("R7 byte2 cfg", d, 8'h83);
        recv_byte(1'b0, d); chk("R7 wrap wiper0", d, 8'h11);
        i2c_stop(); quarter();

        // R8 single-byte read
        i2c_start();
        send_byte({DEV, 1'b1}, a1);
        recv_byte(1'b0, d); chk("R8 single read", d, 8'h11);
        i2c_stop(); quarter();

        // R8 repeated start restarts rotation
        i2c_start();
        send_byte({DEV, 1'b1}, a1);
        recv_byte(1'b1, d);
        recv_byte(1'b0, d); chk("R8 second byte", d, 8'h4C);
        i2c_start();
        send_byte({DEV, 1'b1}, a1);
        recv_byte(1'b0, d); chk("R8 after repeated start", d, 8'h11);
        i2c_stop(); quarter();

        // R8 R11 write, repeated start, read
        p0 = stop_cnt;
        i2c_start();
        send_byte({DEV, 1'b0}, a1);
        send_byte(8'h22, a2);
        i2c_start();
        send_byte({DEV, 1'b1}, a1);
        recv_byte(1'b0, d); chk("R8 read after write", d, 8'h22);
        i2c_stop(); quarter();
        chk("R11 stop after repeated start", stop_cnt - p0, 1);

        // R9 address mismatch: no ack, following byte ignored
        s0 = strobe_cnt; p0 = stop_cnt;
        write1(7'h2B, 8'h00, a1, a2);
        chk("R9 mismatch addr nack", a1, 0);
        chk("R9 mismatch data nack", a2, 0);
        chk("R9 wiper0 unchanged", wiper0_o, 6'h22);
        chk("R9 no strobe", strobe_cnt - s0, 0);
        chk("R9 no stop strobe", stop_cnt - p0, 0);

        // R1 busy suppresses acknowledge
        busy_i = 1'b1;
        write1(DEV, 8'h05, a1, a2);
        busy_i = 1'b0;
        chk("R1 busy nack", a1, 0);
        chk("R1 busy wiper0 unchanged", wiper0_o, 6'h22);

        // R2 chip enable high ignores the bus
        ce_n = 1'b1; quarter();
        write1(DEV, 8'h07, a1, a2);
        chk("R2 disabled nack", a1, 0);
        chk("R2 disabled wiper0 unchanged", wiper0_o, 6'h22);
        ce_n = 1'b0; quarter();

        // R1 strap pins select the address
        addr_pins = 3'b101; quarter();
        write1(7'h2D, 8'h09, a1, a2);
        chk("R1 new pins ack", a1, 1);
        chk("R1 new pins wiper0", wiper0_o, 6'h09);
        write1(DEV, 8'h0B, a1, a2);
        chk("R1 old address nack", a1, 0);
        chk("R1 old address no write", wiper0_o, 6'h09);

        finish_run();
    end
endmodule